// File: doc/BRIEF.md
# Packed Pixel Unpacker with Palette

The block turns a stream of 32-bit frame-buffer words into a stream of 16-bit display pixels. At the start of a frame it takes a pixel size (1, 2, 4, 8 or 16 bits per pixel), a frame length in pixels and a base byte address. It then requests words one at a time and publishes the word address. Each accepted word is cut into pixel fields, lowest bits first. At 1 to 8 bits per pixel each field is an index into an on-chip 256-entry palette of 16-bit colours. At 16 bits per pixel the two halves of the word go out as raw RGB data, low half first.

The palette is loaded through a 32-bit write port that stores two entries per write. Colour entries are laid out red[15:11], green[10:5], blue[4:0]. Monochrome entries keep the grey level in bits 7:0. The block passes entries through unchanged and does not interpret them. Words arrive on a valid/ready handshake and pixels leave on a valid/ready handshake. The pixel that ends the frame carries an end-of-frame flag.

A small controller state machine runs the block. It has three states:
- `ST_IDLE`: no frame is active and both handshakes are inactive.
- `ST_FETCH`: a word is requested.
- `ST_EMIT`: the pixels of the held word are offered.

The transitions are named as follows:
- `start`: a frame-start pulse moves any state to `ST_FETCH`, or to `ST_IDLE` when the frame length is zero.
- `word_taken`: `ST_FETCH` moves to `ST_EMIT`.
- `word_drained`: after the last pixel of a word, `ST_EMIT` moves back to `ST_FETCH`.
- `frame_done`: after the last pixel of the frame, `ST_EMIT` moves to `ST_IDLE`.

Top module: `pxu_top`

## Requirements
- R1: After reset `word_ready`, `pix_valid` and `pix_eof` are all 0.
- R2: A cycle with `frame_start`=1 and a nonzero `cfg_frame_pixels` makes `word_ready`=1 in the next cycle, with `fetch_addr` equal to `cfg_base_addr`.
- R3: `word_ready` is never 1 while `pix_valid` is 1. No new word is requested until every pixel of the held word has been accepted.
- R4: Pixel k of a word (k from 0) is taken from bits [k*b+b-1 : k*b], where b is the pixel size. `cfg_bpp` encodings are 0=1, 1=2, 2=4, 3=8 and 4=16 bits per pixel. A word therefore yields 32, 16, 8, 4 or 2 pixels, and indices are limited to 0–1, 0–3, 0–15 or 0–255 by the field width.
- R5: A palette write at word address a stores `pal_wr_data[15:0]` as entry 2a and `pal_wr_data[31:16]` as entry 2a+1. In palette modes, `pix_data` is the entry selected by the pixel index.
- R6: At 16 bits per pixel the palette is bypassed. `pix_data` is `word[15:0]` for the first pixel and `word[31:16]` for the second.
- R7: `fetch_addr` advances by 4 after each accepted word.
- R8: `pix_eof` is 1 exactly on the pixel numbered `cfg_frame_pixels`-1. After that pixel is accepted, `pix_valid` and `word_ready` stay 0 until the next frame start.
- R9: While `pix_valid`=1 and `pix_ready`=0, with no palette write, `pix_valid` and `pix_data` hold their values.
- R10: A palette write to the entry being shown does not change `pix_data` in the write cycle. The new value appears from the next cycle on.
- R11: The pixel size is captured at frame start. Changes on `cfg_bpp` during a frame have no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | Pulse that starts a frame and captures the configuration |
| cfg_bpp | input | 3 | Pixel size code (0..4) |
| cfg_frame_pixels | input | 20 | Pixels in the frame |
| cfg_base_addr | input | 32 | Byte address of the first frame word |
| pal_wr_en | input | 1 | Palette write strobe |
| pal_wr_addr | input | 7 | Palette word address (entry pair) |
| pal_wr_data | input | 32 | Two palette entries, even entry in the low half |
| fetch_addr | output | 32 | Byte address of the requested word |
| word_valid | input | 1 | Frame word available |
| word_data | input | 32 | Frame word |
| word_ready | output | 1 | Block accepts a word |
| pix_valid | output | 1 | Pixel available |
| pix_data | output | 16 | Pixel colour or raw RGB |
| pix_eof | output | 1 | Current pixel is the last of the frame |
| pix_ready | input | 1 | Sink accepts the pixel |

## Verification
A palette write and a palette lookup can fall in the same cycle. This happens when software reloads an entry while that entry is being shown to a stalled sink. The bench provokes it by holding `pix_ready` low on an 8-bit pixel and rewriting the entry pair that contains its index. It expects the old colour during the write cycle and the new colour one cycle later. Sink stalls during palette frames exercise the second overlap: a pending pixel coinciding with a word offer. There the bench expects `word_ready` to stay low and the pixel to hold.

// File: rtl/pxu_pkg.sv
package pxu_pkg;

    localparam int WORD_W  = 32;
    localparam int PIX_W   = 16;
    localparam int SLOT_W  = 5;
    localparam int PPW_W   = 6;

    typedef enum logic [2:0] {
        BPP1  = 3'd0,
        BPP2  = 3'd1,
        BPP4  = 3'd2,
        BPP8  = 3'd3,
        BPP16 = 3'd4
    } bpp_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_EMIT  = 2'd2
    } ctl_state_e;

    // pixels held by one word for a given pixel size
    function automatic logic [PPW_W-1:0] pix_per_word(bpp_e m);
        logic [PPW_W-1:0] r;
        unique case (m)
            BPP1:    r = 6'd32;
            BPP2:    r = 6'd16;
            BPP4:    r = 6'd8;
            BPP8:    r = 6'd4;
            default: r = 6'd2;
        endcase
        return r;
    endfunction

    // clamp an arbitrary code onto a legal size
    function automatic bpp_e decode_bpp(logic [2:0] code);
        bpp_e r;
        unique case (code)
            3'd0:    r = BPP1;
            3'd1:    r = BPP2;
            3'd2:    r = BPP4;
            3'd3:    r = BPP8;
            default: r = BPP16;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pxu_palette.sv
module pxu_palette #(
    parameter int ENTRIES = 256,
    parameter int ENT_W   = 16,
    localparam int PAIRS   = ENTRIES / 2,
    localparam int IDX_W   = $clog2(ENTRIES),
    localparam int PAIR_AW = $clog2(PAIRS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [PAIR_AW-1:0] wr_addr,
    input  logic [2*ENT_W-1:0] wr_data,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [ENT_W-1:0]   rd_data
);

    logic [ENT_W-1:0] even_mem [PAIRS];
    logic [ENT_W-1:0] odd_mem  [PAIRS];

    // two banks, even entries in the low half of a write, odd in the high
    always_ff @(posedge clk) begin
        if (wr_en) begin
            even_mem[wr_addr] <= wr_data[ENT_W-1:0];
            odd_mem[wr_addr]  <= wr_data[2*ENT_W-1:ENT_W];
        end
    end

    logic [PAIR_AW-1:0] rd_pair;
    assign rd_pair = rd_idx[IDX_W-1:1];

    always_comb begin
        if (rd_idx[0]) rd_data = odd_mem[rd_pair];
        else           rd_data = even_mem[rd_pair];
    end

    assert_pair_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (even_mem[$past(wr_addr)] == $past(wr_data[ENT_W-1:0]))
               && (odd_mem[$past(wr_addr)]  == $past(wr_data[2*ENT_W-1:ENT_W])));

endmodule

// File: rtl/pxu_slicer.sv
module pxu_slicer
    import pxu_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word_in,
    input  bpp_e              mode,
    input  logic [SLOT_W-1:0] slot,
    output logic [IDX_W-1:0]  idx,
    output logic [PIX_W-1:0]  raw
);

    logic [WORD_W-1:0] word_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    word_q <= '0;
        else if (load) word_q <= word_in;
    end

    // field position = slot * 2^mode, lowest field first
    logic [SLOT_W-1:0] shamt;
    logic [WORD_W-1:0] shifted;
    logic [IDX_W-1:0]  field_mask;

    assign shamt   = SLOT_W'(slot << mode);
    assign shifted = word_q >> shamt;

    always_comb begin
        unique case (mode)
            BPP1:    field_mask = IDX_W'(8'h01);
            BPP2:    field_mask = IDX_W'(8'h03);
            BPP4:    field_mask = IDX_W'(8'h0F);
            default: field_mask = IDX_W'(8'hFF);
        endcase
    end

    assign idx = shifted[IDX_W-1:0] & field_mask;
    assign raw = shifted[PIX_W-1:0];

    assert_idx_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == BPP4) |-> (idx < IDX_W'(16)));

endmodule

// File: rtl/pxu_ctrl.sv
module pxu_ctrl
    import pxu_pkg::*;
#(
    parameter int FRAME_W = 20,
    parameter int ADDR_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_start,
    input  logic [2:0]         cfg_bpp,
    input  logic [FRAME_W-1:0] cfg_frame_pixels,
    input  logic [ADDR_W-1:0]  cfg_base_addr,
    input  logic               word_valid,
    input  logic               pix_ready,
    output logic               word_ready,
    output logic               word_load,
    output logic               pix_valid,
    output logic               pix_eof,
    output logic [ADDR_W-1:0]  fetch_addr,
    output bpp_e               mode,
    output logic [SLOT_W-1:0]  slot
);

    localparam logic [ADDR_W-1:0] WORD_BYTES = ADDR_W'(WORD_W / 8);

    ctl_state_e        state_q, state_d;
    bpp_e              mode_q;
    logic [FRAME_W-1:0] len_q, cnt_q;
    logic [SLOT_W-1:0] slot_q;
    logic [ADDR_W-1:0] addr_q;

    logic word_take, pix_take, last_in_word, last_in_frame;

    assign last_in_word  = (PPW_W'(slot_q) == pix_per_word(mode_q) - PPW_W'(1));
    assign last_in_frame = (cnt_q == len_q - FRAME_W'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (frame_start) begin
            state_d = (cfg_frame_pixels == '0) ? ST_IDLE : ST_FETCH;   // start
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_FETCH: if (word_valid) state_d = ST_EMIT;          // word_taken
                ST_EMIT: begin
                    if (pix_ready) begin
                        if (last_in_frame)     state_d = ST_IDLE;     // frame_done
                        else if (last_in_word) state_d = ST_FETCH;    // word_drained
                    end
                end
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        word_ready = 1'b0;
        pix_valid  = 1'b0;
        pix_eof    = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_FETCH: word_ready = 1'b1;
            ST_EMIT: begin
                pix_valid = 1'b1;
                pix_eof   = last_in_frame;
            end
            default:  ;
        endcase
    end

    assign word_take = word_ready & word_valid & ~frame_start;
    assign pix_take  = pix_valid & pix_ready & ~frame_start;
    assign word_load = word_take;

    // frame counters and address
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= BPP1;
            len_q  <= '0;
            cnt_q  <= '0;
            slot_q <= '0;
            addr_q <= '0;
        end else if (frame_start) begin
            mode_q <= decode_bpp(cfg_bpp);
            len_q  <= cfg_frame_pixels;
            cnt_q  <= '0;
            slot_q <= '0;
            addr_q <= cfg_base_addr;
        end else begin
            if (word_take) begin
                addr_q <= addr_q + WORD_BYTES;
                slot_q <= '0;
            end
            if (pix_take) begin
                cnt_q  <= cnt_q + FRAME_W'(1);
                slot_q <= slot_q + SLOT_W'(1);
            end
        end
    end

    assign fetch_addr = addr_q;
    assign mode       = mode_q;
    assign slot       = slot_q;

    assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && cfg_frame_pixels != '0) |=>
            (word_ready && fetch_addr == $past(cfg_base_addr)));

    assert_ready_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(word_ready && pix_valid));

    assert_addr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (word_ready && word_valid && !frame_start) |=>
            (fetch_addr == $past(fetch_addr) + WORD_BYTES));

    assert_eof_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_eof && pix_ready && !frame_start) |=> (!pix_valid && !word_ready));

    assert_mode_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(mode));

endmodule

// File: rtl/pxu_top.sv
module pxu_top
    import pxu_pkg::*;
#(
    parameter int FRAME_W     = 20,
    parameter int ADDR_W      = 32,
    parameter int PAL_ENTRIES = 256,
    localparam int IDX_W      = $clog2(PAL_ENTRIES),
    localparam int PAIR_AW    = $clog2(PAL_ENTRIES / 2)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_start,
    input  logic [2:0]         cfg_bpp,
    input  logic [FRAME_W-1:0] cfg_frame_pixels,
    input  logic [ADDR_W-1:0]  cfg_base_addr,
    input  logic               pal_wr_en,
    input  logic [PAIR_AW-1:0] pal_wr_addr,
    input  logic [31:0]        pal_wr_data,
    output logic [ADDR_W-1:0]  fetch_addr,
    input  logic               word_valid,
    input  logic [31:0]        word_data,
    output logic               word_ready,
    output logic               pix_valid,
    output logic [15:0]        pix_data,
    output logic               pix_eof,
    input  logic               pix_ready
);

    bpp_e              mode;
    logic [SLOT_W-1:0] slot;
    logic              word_load;
    logic [IDX_W-1:0]  idx;
    logic [PIX_W-1:0]  raw, pal_rd;

    pxu_ctrl #(.FRAME_W(FRAME_W), .ADDR_W(ADDR_W)) ctrl_i (
        .clk, .rst_n, .frame_start, .cfg_bpp, .cfg_frame_pixels, .cfg_base_addr,
        .word_valid, .pix_ready, .word_ready, .word_load, .pix_valid, .pix_eof,
        .fetch_addr, .mode, .slot
    );

    pxu_slicer #(.IDX_W(IDX_W)) slicer_i (
        .clk, .rst_n, .load(word_load), .word_in(word_data),
        .mode, .slot, .idx, .raw
    );

    pxu_palette #(.ENTRIES(PAL_ENTRIES), .ENT_W(PIX_W)) pal_i (
        .clk, .rst_n, .wr_en(pal_wr_en), .wr_addr(pal_wr_addr),
        .wr_data(pal_wr_data), .rd_idx(idx), .rd_data(pal_rd)
    );

    assign pix_data = (mode == BPP16) ? raw : pal_rd;

    assert_reset_quiet_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (!pix_valid && !word_ready && !pix_eof));

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !pix_ready && !frame_start && !pal_wr_en) |=>
            (pix_valid && $stable(pix_data)));

    assert_wr_next_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !pix_ready && !frame_start && pal_wr_en && mode != BPP16
         && idx[IDX_W-1:1] == pal_wr_addr) |=>
            (pix_data == (idx[0] ? $past(pal_wr_data[31:16]) : $past(pal_wr_data[15:0]))));

endmodule

// File: tb/pxu_top_tb_top.sv
module pxu_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic [2:0]  cfg_bpp = '0;
    logic [19:0] cfg_frame_pixels = '0;
    logic [31:0] cfg_base_addr = '0;
    logic        pal_wr_en = 1'b0;
    logic [6:0]  pal_wr_addr = '0;
    logic [31:0] pal_wr_data = '0;
    logic [31:0] fetch_addr;
    logic        word_valid = 1'b0;
    logic [31:0] word_data = '0;
    logic        word_ready;
    logic        pix_valid;
    logic [15:0] pix_data;
    logic        pix_eof;
    logic        pix_ready = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [15:0] pal_model [256];
    logic [31:0] wbuf [8];

    always #2.5 clk = ~clk;

    pxu_top dut_i (
        .clk, .rst_n, .frame_start, .cfg_bpp, .cfg_frame_pixels, .cfg_base_addr,
        .pal_wr_en, .pal_wr_addr, .pal_wr_data, .fetch_addr, .word_valid,
        .word_data, .word_ready, .pix_valid, .pix_data, .pix_eof, .pix_ready
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [15:0] pal_val(input int e);
        return 16'(e * 16'h0135) ^ 16'hC3A5;
    endfunction

    function automatic logic [15:0] exp_pix(input int mode, input int pi);
        int bits, ppw, slot;
        logic [31:0] sh;
        bits = 1 << mode;
        ppw  = 32 / bits;
        slot = pi % ppw;
        sh   = wbuf[pi / ppw] >> (slot * bits);
        if (mode == 4) return sh[15:0];
        return pal_model[int'(sh & ((32'd1 << bits) - 1))];
    endfunction

    task automatic pal_write(input int a, input logic [31:0] d);
        pal_wr_en   = 1'b1;
        pal_wr_addr = 7'(a);
        pal_wr_data = d;
        tick();
        pal_wr_en   = 1'b0;
        pal_model[2*a]   = d[15:0];
        pal_model[2*a+1] = d[31:16];
    endtask

    task automatic start_frame(input int mode, input int npix, input logic [31:0] base);
        cfg_bpp          = 3'(mode);
        cfg_frame_pixels = 20'(npix);
        cfg_base_addr    = base;
        frame_start      = 1'b1;
        tick();
        frame_start      = 1'b0;
        chk(word_ready === 1'b1 && fetch_addr === base, "R2 start", fetch_addr, base);
    endtask

    // feeds words and consumes pixels, checking each one
    task automatic run_frame(input int mode, input int npix, input logic [31:0] base,
                             input bit stall, input int alt_bpp, input string req);
        int wi = 0, pi = 0, cyc = 0;
        start_frame(mode, npix, base);
        while (pi < npix && cyc < 2000) begin
            if (alt_bpp >= 0 && cyc == 2) cfg_bpp = 3'(alt_bpp);
            pix_ready  = stall ? (cyc % 3 != 0) : 1'b1;
            word_valid = (wi < 8);
            word_data  = wbuf[wi % 8];
            if (word_ready) begin
                chk(fetch_addr === base + 32'(4*wi), "R7 address", fetch_addr, base + 32'(4*wi));
                chk(pix_valid === 1'b0, "R3 exclusive", {31'd0, pix_valid}, 32'd0);
                wi++;
            end
            if (pix_valid) begin
                chk(pix_data === exp_pix(mode, pi), req, {16'd0, pix_data},
                    {16'd0, exp_pix(mode, pi)});
                chk(pix_eof === (pi == npix - 1), "R8 eof", {31'd0, pix_eof},
                    {31'd0, pi == npix - 1});
                if (!pix_ready)
                    chk(word_ready === 1'b0, "R3 held", {31'd0, word_ready}, 32'd0);
                else pi++;
            end
            tick();
            cyc++;
        end
        chk(pi == npix, "R8 frame complete", 32'(pi), 32'(npix));
        word_valid = 1'b1;
        tick();
        tick();
        chk(pix_valid === 1'b0 && word_ready === 1'b0, "R8 idle after frame",
            {30'd0, pix_valid, word_ready}, 32'd0);
        word_valid = 1'b0;
        pix_ready  = 1'b0;
        cfg_bpp    = 3'(mode);
    endtask

    task automatic test_reset();
        chk(word_ready === 1'b0, "R1 word_ready", {31'd0, word_ready}, 32'd0);
        chk(pix_valid === 1'b0, "R1 pix_valid", {31'd0, pix_valid}, 32'd0);
        chk(pix_eof === 1'b0, "R1 pix_eof", {31'd0, pix_eof}, 32'd0);
    endtask

    task automatic test_load_palette();
        for (int a = 0; a < 128; a++) pal_write(a, {pal_val(2*a+1), pal_val(2*a)});
    endtask

    task automatic test_1bpp();
        wbuf[0] = 32'h8000_0001;
        wbuf[1] = 32'h5555_AAAA;
        run_frame(0, 64, 32'h0000_1000, 1'b0, -1, "R4 1bpp order");
    endtask

    task automatic test_2bpp();
        wbuf[0] = 32'hE4E4_1B1B;
        run_frame(1, 16, 32'h0000_2000, 1'b0, -1, "R4 2bpp order");
    endtask

    task automatic test_4bpp_stall();
        wbuf[0] = 32'hFEDC_BA98;
        wbuf[1] = 32'h7654_3210;
        run_frame(2, 16, 32'h0000_3000, 1'b1, -1, "R9 4bpp stalled");
    endtask

    task automatic test_8bpp();
        wbuf[0] = 32'h807E_01FF;
        wbuf[1] = 32'h0011_2233;
        run_frame(3, 8, 32'h0000_4000, 1'b0, -1, "R5 8bpp lookup");
    endtask

    task automatic test_16bpp();
        wbuf[0] = 32'h1234_ABCD;
        wbuf[1] = 32'hFFFF_0000;
        run_frame(4, 4, 32'h0000_5000, 1'b1, -1, "R6 raw bypass");
    endtask

    task automatic test_mode_change();
        wbuf[0] = 32'h0F1E_2D3C;
        run_frame(2, 8, 32'h0000_6000, 1'b0, 4, "R11 size held");
    endtask

    task automatic test_write_collision();
        logic [15:0] oldv, newv;
        int cyc = 0;
        wbuf[0] = 32'h0302_0105;
        start_frame(3, 4, 32'h0000_7000);
        word_valid = 1'b1;
        word_data  = wbuf[0];
        pix_ready  = 1'b0;
        tick();
        word_valid = 1'b0;
        oldv = pal_model[5];
        newv = 16'hBEEF;
        chk(pix_valid === 1'b1 && pix_data === oldv, "R10 before write",
            {16'd0, pix_data}, {16'd0, oldv});
        pal_wr_en   = 1'b1;
        pal_wr_addr = 7'd2;
        pal_wr_data = {newv, pal_model[4]};
        #1;
        chk(pix_data === oldv, "R10 write cycle shows old", {16'd0, pix_data}, {16'd0, oldv});
        tick();
        pal_wr_en = 1'b0;
        pal_model[5] = newv;
        chk(pix_data === newv, "R10 next cycle shows new", {16'd0, pix_data}, {16'd0, newv});
        pix_ready = 1'b1;
        while (pix_valid && cyc < 10) begin
            tick();
            cyc++;
        end
        chk(pix_valid === 1'b0, "R8 collision frame ends", {31'd0, pix_valid}, 32'd0);
        pix_ready = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) pal_model[i] = '0;
        for (int i = 0; i < 8; i++) wbuf[i] = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        test_reset();
        test_load_palette();
        test_1bpp();
        test_2bpp();
        test_4bpp_stall();
        test_8bpp();
        test_16bpp();
        test_mode_change();
        test_write_collision();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule